// File: doc/BRIEF.md
# Single-Operand Microcode ALU

This block is a purely combinational 8-bit arithmetic and logic unit that works on one operand. A microcoded 8-bit controller drives it with a byte `opnd_a`, a single carry-style bit `carry_in` and a 4-bit operation code `op_sel`, and takes the byte `result` in the same cycle. The sixteen operations cover what such a controller needs between register-file reads and writes: moving status bits into the places later steps expect, rotating (with or without the carry bit), nibble exchange, stepping a byte up or down, splitting a bit address into a byte address and a bit position, placing the carry bit, and a few helpers for interrupt entry and return.

One operation maps a special-register address to an index in the register file. The table is a parameter array of (address, index) pairs that is fixed when the design is built. The other operations have no state and no parameters.

Top module: `sop_alu`

## Requirements
- R1: Code 0 (status-bit exchange) returns `opnd_a` with bits 6 and 3 exchanged; all other bits are unchanged.
- R2: Code 1 (vector address) returns eight times `opnd_a[1:0]` plus three, i.e. one of 0x03, 0x0B, 0x13, 0x1B.
- R3: Code 2 returns `opnd_a` when `carry_in` is 1 and 0x00 when it is 0.
- R4: Code 3 (register map) looks `opnd_a` up in the table. On a hit, bit 4 is 1, bits 3:0 hold the table index and bits 7:5 are 0. On a miss the result is 0x00. The default table maps 0xF0 to 1, 0xE0 to 0, 0xD0 to 2 and 0x81 to 3. When two entries match, the entry that comes first in the table wins.
- R5: Code 4 rotates right by one and code 5 rotates left by one, both within the byte.
- R6: Code 6 shifts right and puts `carry_in` into bit 7. Code 7 shifts left and puts `carry_in` into bit 0. The bit shifted out is discarded.
- R7: Code 8 adds one and code 9 subtracts one, modulo 256 (0xFF+1 gives 0x00, 0x00-1 gives 0xFF).
- R8: Code 10 (byte address) returns 0x20 + (`opnd_a` >> 3) when `opnd_a` < 0x80, and `opnd_a` with its low three bits cleared otherwise.
- R9: Code 11 (bit position) returns `opnd_a[2:0]` in both bits 2:0 and bits 6:4, with bits 7 and 3 zero.
- R10: Code 12 returns `carry_in` in bit 7 and `opnd_a[6:0]` in bits 6:0.
- R11: Code 13 (interrupt pick) reads each nibble as {valid (bit 3), priority (bit 2), number (bits 1:0)}, with the low nibble as group 0 and the high nibble as group 1. It picks group 1 only if group 1 is valid and either group 0 is invalid or group 1 has priority 1 while group 0 has priority 0. The result has the chosen priority in bit 7, the chosen group in bit 2, the chosen number in bits 1:0 and zero in bits 6:3. If no group is valid, the result is 0x00.
- R12: Code 14 (service clear) keeps bits 7 and 4:0 and forces bit 6 to 0. Bit 5 is kept when `opnd_a[6]` is 1 and cleared when it is 0.
- R13: Code 15 exchanges the high and low nibbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code, 0 to 15 |
| opnd_a | input | 8 | Byte operand |
| carry_in | input | 1 | Single-bit operand used by codes 2, 6, 7 and 12 |
| result | output | 8 | Combinational result |

## Verification
The cases hardest to reach from the ports are the interrupt-pick decisions. Both nibbles must be valid, with every combination of the two priority bits, while the numbers differ so that a wrong group choice shows up in bits 2:0. A second hard case is a register-map hit on each of the four table addresses, among 252 addresses that miss. The stimulus sweeps all 256 operand values for every code with both carry values. This reaches every priority combination, every table hit and every wrap point of increment and decrement. An independent model built from the requirements predicts each result.

// File: rtl/sop_alu_pkg.sv
package sop_alu_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [3:0] {
        OP_FLAGSWAP = 4'd0,
        OP_VECADR   = 4'd1,
        OP_MASKC    = 4'd2,
        OP_REGMAP   = 4'd3,
        OP_ROR      = 4'd4,
        OP_ROL      = 4'd5,
        OP_RORC     = 4'd6,
        OP_ROLC     = 4'd7,
        OP_INC      = 4'd8,
        OP_DEC      = 4'd9,
        OP_BYTEADR  = 4'd10,
        OP_BITPOS   = 4'd11,
        OP_CARRYIN  = 4'd12,
        OP_IRQPICK  = 4'd13,
        OP_SVCCLR   = 4'd14,
        OP_NIBSWAP  = 4'd15
    } op_e;

    typedef struct packed {
        logic       valid;
        logic       prio;
        logic [1:0] num;
    } irq_grp_t;

    typedef enum logic [1:0] {
        UNIT_PERM,
        UNIT_ARITH,
        UNIT_IRQ,
        UNIT_MAP
    } unit_e;

    function automatic unit_e unit_of(input op_e op);
        case (op)
            OP_VECADR, OP_INC, OP_DEC, OP_BYTEADR: unit_of = UNIT_ARITH;
            OP_IRQPICK, OP_SVCCLR:                 unit_of = UNIT_IRQ;
            OP_REGMAP:                             unit_of = UNIT_MAP;
            default:                               unit_of = UNIT_PERM;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] nib_swap(input logic [BYTE_W-1:0] v);
        nib_swap = {v[NIB_W-1:0], v[BYTE_W-1:NIB_W]};
    endfunction

endpackage

// File: rtl/sop_perm_unit.sv
module sop_perm_unit
    import sop_alu_pkg::*;
(
    input  op_e               op,
    input  logic [BYTE_W-1:0] a,
    input  logic              c,
    output logic [BYTE_W-1:0] r
);
    always_comb begin
        case (op)
            OP_FLAGSWAP: r = {a[7], a[3], a[5:4], a[6], a[2:0]};
            OP_MASKC:    r = a & {BYTE_W{c}};
            OP_ROR:      r = {a[0], a[BYTE_W-1:1]};
            OP_ROL:      r = {a[BYTE_W-2:0], a[BYTE_W-1]};
            OP_RORC:     r = {c, a[BYTE_W-1:1]};
            OP_ROLC:     r = {a[BYTE_W-2:0], c};
            OP_BITPOS:   r = {1'b0, a[2:0], 1'b0, a[2:0]};
            OP_CARRYIN:  r = {c, a[BYTE_W-2:0]};
            OP_NIBSWAP:  r = nib_swap(a);
            default:     r = '0;
        endcase
    end
endmodule

// File: rtl/sop_arith_unit.sv
module sop_arith_unit
    import sop_alu_pkg::*;
(
    input  op_e               op,
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] r
);
    localparam logic [BYTE_W-1:0] BIT_RAM_BASE = 8'h20;
    localparam logic [BYTE_W-1:0] VEC_OFFSET   = 8'h03;

    logic [BYTE_W-1:0] addend;
    logic [BYTE_W-1:0] base;
    logic [BYTE_W-1:0] sum;

    always_comb begin
        base   = a;
        addend = '0;
        case (op)
            OP_VECADR: begin
                base   = {3'b0, a[1:0], 3'b0};
                addend = VEC_OFFSET;
            end
            OP_INC:  addend = 8'h01;
            OP_DEC:  addend = 8'hFF;
            OP_BYTEADR: begin
                if (a[BYTE_W-1]) begin
                    base   = {a[BYTE_W-1:3], 3'b0};
                    addend = '0;
                end else begin
                    base   = {3'b0, a[BYTE_W-1:3]};
                    addend = BIT_RAM_BASE;
                end
            end
            default: addend = '0;
        endcase
    end

    assign sum = base + addend;
    assign r   = sum;
endmodule

// File: rtl/sop_irq_unit.sv
module sop_irq_unit
    import sop_alu_pkg::*;
(
    input  op_e               op,
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] r
);
    irq_grp_t grp_lo, grp_hi;
    logic     take_hi;
    logic     any_valid;
    irq_grp_t chosen;
    logic [BYTE_W-1:0] pick_r, clr_r;

    assign grp_lo    = irq_grp_t'(a[NIB_W-1:0]);
    assign grp_hi    = irq_grp_t'(a[BYTE_W-1:NIB_W]);
    assign take_hi   = grp_hi.valid && (!grp_lo.valid || (grp_hi.prio && !grp_lo.prio));
    assign any_valid = grp_lo.valid | grp_hi.valid;
    assign chosen    = take_hi ? grp_hi : grp_lo;

    assign pick_r = any_valid ? {chosen.prio, 4'b0, take_hi, chosen.num} : '0;
    assign clr_r  = {a[7], 1'b0, a[6] & a[5], a[4:0]};

    always_comb begin
        case (op)
            OP_IRQPICK: r = pick_r;
            OP_SVCCLR:  r = clr_r;
            default:    r = '0;
        endcase
    end
endmodule

// File: rtl/sop_map_unit.sv
module sop_map_unit
    import sop_alu_pkg::*;
#(
    parameter int MAP_COUNT = 4,
    parameter logic [MAP_COUNT-1:0][BYTE_W-1:0] MAP_ADDR = {8'h81, 8'hD0, 8'hE0, 8'hF0},
    parameter logic [MAP_COUNT-1:0][NIB_W-1:0]  MAP_IDX  = {4'd3, 4'd2, 4'd0, 4'd1}
) (
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] r
);
    logic [MAP_COUNT-1:0] hit;
    logic [NIB_W-1:0]     idx;
    logic                 any_hit;

    for (genvar i = 0; i < MAP_COUNT; i++) begin : g_cmp
        assign hit[i] = (a == MAP_ADDR[i]);
    end

    always_comb begin
        idx = '0;
        for (int i = MAP_COUNT - 1; i >= 0; i--) begin
            if (hit[i]) idx = MAP_IDX[i];
        end
    end

    assign any_hit = |hit;
    assign r = {3'b0, any_hit, idx};
endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_alu_pkg::*;
#(
    parameter int MAP_COUNT = 4,
    parameter logic [MAP_COUNT-1:0][7:0] MAP_ADDR = {8'h81, 8'hD0, 8'hE0, 8'hF0},
    parameter logic [MAP_COUNT-1:0][3:0] MAP_IDX  = {4'd3, 4'd2, 4'd0, 4'd1}
) (
    input  logic [3:0] op_sel,
    input  logic [7:0] opnd_a,
    input  logic       carry_in,
    output logic [7:0] result
);
    op_e op;
    logic [BYTE_W-1:0] perm_r, arith_r, irq_r, map_r;

    assign op = op_e'(op_sel);

    sop_perm_unit u_perm (
        .op (op),
        .a  (opnd_a),
        .c  (carry_in),
        .r  (perm_r)
    );

    sop_arith_unit u_arith (
        .op (op),
        .a  (opnd_a),
        .r  (arith_r)
    );

    sop_irq_unit u_irq (
        .op (op),
        .a  (opnd_a),
        .r  (irq_r)
    );

    sop_map_unit #(
        .MAP_COUNT (MAP_COUNT),
        .MAP_ADDR  (MAP_ADDR),
        .MAP_IDX   (MAP_IDX)
    ) u_map (
        .a (opnd_a),
        .r (map_r)
    );

    always_comb begin
        case (unit_of(op))
            UNIT_ARITH: result = arith_r;
            UNIT_IRQ:   result = irq_r;
            UNIT_MAP:   result = map_r;
            default:    result = perm_r;
        endcase
    end
endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk (
    input logic [3:0] op_sel,
    input logic [7:0] opnd_a,
    input logic       carry_in,
    input logic [7:0] result
);
    always_comb begin
        if (op_sel == 4'd0)
            AST_FLAG_EXCHANGE: assert (result[6] == opnd_a[3] && result[3] == opnd_a[6]) else $error("flag exchange"); // R1
        if (op_sel == 4'd1)
            AST_VECTOR_FORM: assert (result[2:0] == 3'b011 && result[7:5] == 3'b000) else $error("vector form"); // R2
        if (op_sel == 4'd2)
            AST_MASK_BY_C: assert (carry_in ? (result == opnd_a) : (result == 8'h00)) else $error("mask"); // R3
        if (op_sel == 4'd3)
            AST_MAP_SHAPE: assert (result[7:5] == 3'b000 && (result[4] || result[3:0] == 4'h0)) else $error("map shape"); // R4
        if (op_sel == 4'd4)
            AST_ROTATE_RIGHT: assert ({result[6:0], result[7]} == opnd_a) else $error("ror"); // R5
        if (op_sel == 4'd7)
            AST_ROTATE_LEFT_C: assert (result[0] == carry_in && result[7:1] == opnd_a[6:0]) else $error("rolc"); // R6
        if (op_sel == 4'd8)
            AST_INC_INVERSE: assert (8'(result - 8'd1) == opnd_a) else $error("inc"); // R7
        if (op_sel == 4'd11)
            AST_BITPOS_COPY: assert (result[6:4] == result[2:0] && !result[7] && !result[3]) else $error("bitpos"); // R9
        if (op_sel == 4'd12)
            AST_CARRY_PLACED: assert (result[7] == carry_in && result[6:0] == opnd_a[6:0]) else $error("carry"); // R10
        if (op_sel == 4'd13)
            AST_PICK_GAP_ZERO: assert (result[6:3] == 4'h0) else $error("pick"); // R11
        if (op_sel == 4'd14)
            AST_SVC_CLEARED: assert (!result[6] && result[7] == opnd_a[7] && (!result[5] || opnd_a[6])) else $error("svc"); // R12
        if (op_sel == 4'd15)
            AST_NIB_EXCHANGE: assert ({result[3:0], result[7:4]} == opnd_a) else $error("swap"); // R13
    end
endmodule

bind sop_alu sop_alu_chk u_chk (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .carry_in (carry_in),
    .result   (result)
);

// File: tb/tb_sop_alu.sv
module tb_sop_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel   = '0;
    logic [7:0] opnd_a   = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] op;
        logic [7:0] a;
        logic       c;
        logic [7:0] exp;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    sop_alu dut (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .carry_in (carry_in),
        .result   (result)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";   4'd1: return "R2";   4'd2: return "R3";
            4'd3: return "R4";   4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";   4'd8, 4'd9: return "R7";
            4'd10: return "R8";  4'd11: return "R9";  4'd12: return "R10";
            4'd13: return "R11"; 4'd14: return "R12"; default: return "R13";
        endcase
    endfunction

    function automatic logic [7:0] model(input logic [3:0] op, input logic [7:0] a, input logic c);
        logic [7:0] q;
        logic lv, lp, hv, hp, hi;
        q = 8'h00;
        case (op)
            4'd0: begin q = a; q[6] = a[3]; q[3] = a[6]; end
            4'd1: q = 8'(a[1:0] * 8 + 3);
            4'd2: q = c ? a : 8'h00;
            4'd3: begin
                if (a == 8'hF0)      q = 8'h11;
                else if (a == 8'hE0) q = 8'h10;
                else if (a == 8'hD0) q = 8'h12;
                else if (a == 8'h81) q = 8'h13;
                else                 q = 8'h00;
            end
            4'd4: q = (a >> 1) | (a << 7);
            4'd5: q = (a << 1) | (a >> 7);
            4'd6: q = (a >> 1) | {c, 7'b0};
            4'd7: q = (a << 1) | {7'b0, c};
            4'd8: q = a + 8'd1;
            4'd9: q = a - 8'd1;
            4'd10: q = (a < 8'h80) ? 8'(8'h20 + (a >> 3)) : (a & 8'hF8);
            4'd11: q = (a & 8'h07) | ((a & 8'h07) << 4);
            4'd12: q = {c, a[6:0]};
            4'd13: begin
                lv = a[3]; lp = a[2]; hv = a[7]; hp = a[6];
                hi = hv && (!lv || (hp && !lp));
                if (!lv && !hv) q = 8'h00;
                else if (hi)    q = {hp, 4'b0, 1'b1, a[5:4]};
                else            q = {lp, 4'b0, 1'b0, a[1:0]};
            end
            4'd14: begin
                q = a;
                if (a[6]) q[6] = 1'b0;
                else      q[5] = 1'b0;
            end
            default: q = {a[3:0], a[7:4]};
        endcase
        return q;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic c);
        item_t it;
        @(posedge clk);
        op_sel   = op;
        opnd_a   = a;
        carry_in = c;
        it.op = op; it.a = a; it.c = c; it.exp = model(op, a, c);
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_run++;
            if (result !== it.exp) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%02h c=%0b actual=%02h expected=%02h",
                         tag_of(it.op), it.op, it.a, it.c, result, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: code 0 with zero operand gives 0x00 (R1)
        drive(4'd0, 8'h00, 1'b0);
        // directed corners: R4 table hits, R7 wrap, R8 boundary, R11 priority, R12 both branches
        drive(4'd3, 8'hF0, 1'b0);
        drive(4'd3, 8'h81, 1'b1);
        drive(4'd3, 8'h80, 1'b0);
        drive(4'd8, 8'hFF, 1'b0);
        drive(4'd9, 8'h00, 1'b1);
        drive(4'd10, 8'h7F, 1'b0);
        drive(4'd10, 8'h80, 1'b0);
        drive(4'd13, 8'hE9, 1'b0);
        drive(4'd13, 8'hCE, 1'b0);
        drive(4'd14, 8'h60, 1'b0);
        drive(4'd14, 8'hBF, 1'b0);
        // full sweep of every code, operand and carry value (R1..R13)
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    drive(4'(op), 8'(a), 1'(c));
                end
            end
        end
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule